// File: doc/BRIEF.md
# Stereo PCM Playout Buffer with One-Bit Pulse-Density Outputs

This block takes 32-bit words of packed stereo PCM audio from a processor write port and queues them in a first-in first-out buffer. A programmable sample-period divider issues a one-cycle sample tick; on each tick a small playout state machine takes one word from the buffer, puts its bytes back in the right order and splits it into a signed 16-bit left sample and a signed 16-bit right sample. Each held sample feeds its own first-order sigma-delta modulator, whose one-bit pulse-density output goes straight to an external amplifier through an analog low-pass filter outside this block.

The writer is expected to keep the buffer topped up. When a tick finds the buffer empty after playback has begun, the block repeats the last sample pair and counts the event in a saturating underrun counter, so software can tell that the writer fell behind. The buffer level and its full and empty flags are visible at the ports, and a write that arrives while the buffer is full is dropped.

The playout state machine has three states. ST_IDLE is the state after reset, before any word has been played. ST_PLAY is entered from ST_IDLE or ST_STARVED on a tick that finds data. ST_STARVED is entered from ST_PLAY on a tick that finds the buffer empty, and left for ST_PLAY on the first tick that finds data again. Every other tick leaves the state unchanged. Everything runs from one clock, which is also the modulator clock.

Top module: `stereo_pdm_player`

## Requirements
- R1: After reset the level is 0, `fifo_empty` is 1, `fifo_full` is 0, the underrun count is 0, both samples are 0, `sample_valid` is 0 and both pulse outputs are 0.
- R2: Each accepted write raises the level by one. `fifo_full` is 1 exactly when the level equals DEPTH. A write while full is dropped and changes neither the level nor the stored data.
- R3: With `div_val` = N, a sample tick occurs every N+1 clock cycles. Each tick that finds data pops exactly one word and pulses `sample_valid` for one cycle, with the new samples, in the cycle after the tick.
- R4: A write word holds four file bytes, file byte 0 in bits 31:24, byte 1 in 23:16, byte 2 in 15:8 and byte 3 in 7:0. The left sample is {byte1, byte0}, the right sample is {byte3, byte2}, both in two's complement.
- R5: Words are played in the order they were written.
- R6: A tick that finds the buffer empty in ST_PLAY or ST_STARVED leaves both samples unchanged, gives no `sample_valid` pulse, and raises the underrun count by one.
- R7: The underrun count saturates at its all-ones value.
- R8: Ticks in ST_IDLE with an empty buffer do not count as underruns.
- R9: Each modulator adds the offset-binary form of its sample (sign bit inverted) into a 16-bit sum, and its output is the registered carry out of that addition. Over 256 cycles with a held sample, 0x0000 gives 128 ones, 0x4000 gives 192 ones, 0x8000 gives no ones and 0x7FFF gives at least 255 ones.
- R10: After an underrun, the next word written is played on the next tick.
- R11: A write and a pop in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the buffer and the modulators |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | 32 | Packed stereo word, byte layout in R4 |
| div_val | input | 16 | Sample period minus one, in clock cycles |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored words |
| fifo_full | output | 1 | Buffer holds DEPTH words |
| fifo_empty | output | 1 | Buffer holds no words |
| underrun_cnt | output | CNT_W | Saturating count of starved ticks |
| left_sample | output | 16 | Current left sample, signed |
| right_sample | output | 16 | Current right sample, signed |
| sample_valid | output | 1 | One-cycle pulse when a new pair is loaded |
| pdm_left | output | 1 | Left pulse-density output |
| pdm_right | output | 1 | Right pulse-density output |

## Verification
The hardest condition to reach from the ports is the ST_STARVED state followed by saturation of the underrun counter and then recovery. The buffer must first be filled and drained by real playout before a starved tick counts. The bench builds with a narrow counter, drains the buffer at a short sample period and lets ticks run on an empty buffer long enough to pin the count. It then writes one more word to see the block return to playback. The modulator densities are checked by counting ones over windows in which the divider is set to its slowest period, so the held sample cannot change.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLAY,
        ST_STARVED
    } po_state_t;

    // Rebuild the left sample from a packed word (R4): file bytes 1,0.
    function automatic logic [15:0] word_left(input logic [31:0] w);
        return {w[23:16], w[31:24]};
    endfunction

    // Rebuild the right sample from a packed word (R4): file bytes 3,2.
    function automatic logic [15:0] word_right(input logic [31:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/spp_fifo.sv
module spp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [LVW-1:0]   level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push;
    logic             pop;

    assign full  = (level == LVW'(DEPTH));
    assign empty = (level == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/spp_sample_timer.sv
module spp_sample_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else if (count >= div_val) begin
            count <= '0;
            tick  <= 1'b1;
        end else begin
            count <= count + 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/spp_playout.sv
module spp_playout
    import spp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [31:0]       rd_data,
    output logic              rd_en,
    output logic [15:0]       left_q,
    output logic [15:0]       right_q,
    output logic              valid_q,
    output logic [CNT_W-1:0]  underruns,
    output po_state_t         state
);
    po_state_t state_nx;
    logic      starve;

    assign rd_en  = tick && !fifo_empty;
    assign starve = tick && fifo_empty && (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (rd_en)  state_nx = ST_PLAY;
            ST_PLAY:    if (starve) state_nx = ST_STARVED;
            ST_STARVED: if (rd_en)  state_nx = ST_PLAY;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q    <= '0;
            right_q   <= '0;
            valid_q   <= 1'b0;
            underruns <= '0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                left_q  <= word_left(rd_data);
                right_q <= word_right(rd_data);
            end
            if (starve && (underruns != {CNT_W{1'b1}})) begin
                underruns <= underruns + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spp_sdm.sv
module spp_sdm #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    output logic          pulse
);
    logic [SW-1:0] acc;
    logic [SW:0]   sum;
    logic [SW-1:0] ofs;

    assign ofs = {~sample[SW-1], sample[SW-2:0]};
    assign sum = {1'b0, acc} + {1'b0, ofs};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else begin
            acc   <= sum[SW-1:0];
            pulse <= sum[SW];
        end
    end

endmodule

// File: rtl/stereo_pdm_player.sv
module stereo_pdm_player
    import spp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 16,
    parameter int DIV_W = 16,
    localparam int LVW  = $clog2(DEPTH + 1),
    localparam int NCH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [DIV_W-1:0] div_val,
    output logic [LVW-1:0]   fifo_level,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic [CNT_W-1:0] underrun_cnt,
    output logic [15:0]      left_sample,
    output logic [15:0]      right_sample,
    output logic             sample_valid,
    output logic             pdm_left,
    output logic             pdm_right
);
    logic        tick;
    logic        rd_en;
    logic [31:0] rd_data;
    po_state_t   po_state;
    logic [15:0] ch_sample [NCH];
    logic        ch_pulse  [NCH];

    spp_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .level   (fifo_level),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    spp_sample_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .tick    (tick)
    );

    spp_playout #(.CNT_W(CNT_W)) u_play (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .rd_data    (rd_data),
        .rd_en      (rd_en),
        .left_q     (left_sample),
        .right_q    (right_sample),
        .valid_q    (sample_valid),
        .underruns  (underrun_cnt),
        .state      (po_state)
    );

    assign ch_sample[0] = left_sample;
    assign ch_sample[1] = right_sample;

    for (genvar c = 0; c < NCH; c++) begin : g_mod
        spp_sdm #(.SW(16)) u_sdm (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (ch_sample[c]),
            .pulse  (ch_pulse[c])
        );
    end

    assign pdm_left  = ch_pulse[0];
    assign pdm_right = ch_pulse[1];

endmodule

// File: rtl/stereo_pdm_checker.sv
module stereo_pdm_checker
    import spp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 16,
    localparam int LVW  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tick,
    input po_state_t        state,
    input logic [LVW-1:0]   fifo_level,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic [CNT_W-1:0] underrun_cnt,
    input logic [15:0]      left_sample,
    input logic [15:0]      right_sample,
    input logic             sample_valid
);
    // R2: a write while full with no pop leaves the level alone
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !tick) |=> (fifo_level == LVW'(DEPTH)));

    // R2: level never exceeds the depth, flags never both set
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level <= LVW'(DEPTH)) && !(fifo_full && fifo_empty));

    // R3: without a tick the samples do not move and no valid pulse follows
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!sample_valid && $stable(left_sample) && $stable(right_sample)));

    // R3: a tick with data yields a valid pulse
    p_tick_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !fifo_empty) |=> sample_valid);

    // R6: a starved tick holds the pair
    p_starve_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fifo_empty) |=> (!sample_valid && $stable(left_sample) && $stable(right_sample)));

    // R6: a starved tick after playback counts once below saturation
    p_starve_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fifo_empty && state != ST_IDLE && underrun_cnt != {CNT_W{1'b1}})
        |=> (underrun_cnt == $past(underrun_cnt) + 1'b1));

    // R7: a saturated count stays put
    p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_cnt == {CNT_W{1'b1}}) |=> (underrun_cnt == {CNT_W{1'b1}}));

    // R8: while idle nothing has been counted
    p_idle_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (underrun_cnt == '0));

endmodule

bind stereo_pdm_player stereo_pdm_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .tick         (tick),
    .state        (po_state),
    .fifo_level   (fifo_level),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .underrun_cnt (underrun_cnt),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid)
);

// File: tb/tb_stereo_pdm_player.sv
module tb_stereo_pdm_player;
    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int LVW   = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [15:0]      div_val = 16'hFFFF;
    logic [LVW-1:0]   fifo_level;
    logic             fifo_full, fifo_empty;
    logic [CNT_W-1:0] underrun_cnt;
    logic [15:0]      left_sample, right_sample;
    logic             sample_valid, pdm_left, pdm_right;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];
    int cyc = 0;
    int last_valid = -1;
    int period_exp = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stereo_pdm_player #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

    function automatic logic [31:0] pack(input logic [15:0] l, input logic [15:0] r);
        return {l[7:0], l[15:8], r[7:0], r[15:8]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: write a pair and record the expected result if accepted
    task automatic put(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        if (!fifo_full) exp_q.push_back({l, r});
        wr_en = 1'b1;
        wr_data = pack(l, r);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: compare every new pair with the scoreboard (R4, R5, R3)
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected pair", {left_sample, right_sample}, 32'hx);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R4/R5 pair", {left_sample, right_sample}, e);
            end
            if (period_exp != 0 && last_valid >= 0)
                check("R3 period", 32'(cyc - last_valid), 32'(period_exp));
            last_valid = cyc;
        end
    end

    task automatic count_ones(output int nl, output int nr);
        nl = 0; nr = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            nl += int'(pdm_left);
            nr += int'(pdm_right);
        end
    endtask

    initial begin
        int nl, nr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 level", 32'(fifo_level), 0);
        check("R1 empty", 32'(fifo_empty), 1);
        check("R1 full", 32'(fifo_full), 0);
        check("R1 underruns", 32'(underrun_cnt), 0);
        check("R1 samples", {left_sample, right_sample}, 0);
        check("R1 outputs", {29'd0, sample_valid, pdm_left, pdm_right}, 0);
        rst_n = 1'b1;
        // R8 ticks while idle and empty
        div_val = 16'd1;
        repeat (20) @(negedge clk);
        check("R8 idle ticks", 32'(underrun_cnt), 0);
        div_val = 16'hFFFF;
        repeat (4) @(negedge clk);
        // R2 fill to full
        for (int k = 0; k < DEPTH; k++) put(16'(k * 16'h1111 + 16'h0102), 16'(16'hA5C3 - k));
        check("R2 level full", 32'(fifo_level), DEPTH);
        check("R2 full flag", 32'(fifo_full), 1);
        put(16'hDEAD, 16'hBEEF);  // dropped, not on the scoreboard
        check("R2 drop level", 32'(fifo_level), DEPTH);
        // R3/R4/R5 drain at period 4
        div_val = 16'd3;
        wait (exp_q.size() == DEPTH - 1);
        period_exp = 4;
        wait (exp_q.size() == 0);
        @(negedge clk);
        period_exp = 0;
        // R6 starve: pair held, count climbs
        repeat (9) @(negedge clk);
        check("R6 hold", {left_sample, right_sample}, {16'(7 * 16'h1111 + 16'h0102), 16'(16'hA5C3 - 7)});
        check("R6 counting", 32'(underrun_cnt >= 2 && underrun_cnt < 15), 1);
        // R7 saturation
        repeat (100) @(negedge clk);
        check("R7 saturate", 32'(underrun_cnt), 15);
        // R10 recovery
        put(16'h1234, 16'hFEDC);
        repeat (10) @(negedge clk);
        check("R10 recovered", 32'(exp_q.size()), 0);
        check("R10 pair", {left_sample, right_sample}, {16'h1234, 16'hFEDC});
        // R11 write and pop together at full rate
        div_val = 16'd0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            exp_q.push_back({16'(k), 16'(k + 100)});
            wr_en = 1'b1;
            wr_data = pack(16'(k), 16'(k + 100));
            @(negedge clk);
            check("R11 level", 32'(fifo_level), 1);
        end
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 drained", 32'(fifo_level), 0);
        // R9 modulator densities
        put(16'h0000, 16'h4000);
        repeat (4) @(negedge clk);
        div_val = 16'hFFFF;
        repeat (4) @(negedge clk);
        count_ones(nl, nr);
        check("R9 left 0x0000", 32'(nl), 128);
        check("R9 right 0x4000", 32'(nr), 192);
        div_val = 16'd0;
        put(16'h8000, 16'h7FFF);
        repeat (4) @(negedge clk);
        div_val = 16'hFFFF;
        repeat (4) @(negedge clk);
        count_ones(nl, nr);
        check("R9 left 0x8000", 32'(nl), 0);
        check("R9 right 0x7FFF", 32'(nr >= 255), 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule